// File: doc/BRIEF.md
# Cascaded Match Priority Arbiter

This block sits in every device of a depth cascade of up to eight search devices. When a lookup completes, it reduces the per-segment hit flags and indices of its own table to one local result. It raises a match-out line that all lower-priority devices see, and from the match lines of the devices above it, it decides whether it owns the shared result bus in the next cycle. No central encoder is involved: each device masks the cascade match lines with its strapped 3-bit identifier, so only devices with a smaller identifier can block it. Device 0 is therefore never blocked.

Each device also pulls a wired-OR multi-match line. It does so when its own table has more than one hit, or when it hits while a higher-priority device has also hit. Two straps pick special roles, and both belong on the lowest-priority device, the only one that sees every hit in the cascade. The last-device strap enables the completion and hit handshake to the host. The last-SRAM strap enables the external SRAM chip-enable and write-enable, and parks the result bus at zero whenever no device owns it. The result word carries the lookup type, the device identifier and the matched location within the device.

All outputs are registered and come one clock after the lookup that caused them. Match-out is combinational, so the whole cascade settles within one cycle.

Top module: `cascade_match_arbiter`

## Requirements
- R1: `match_out` is high in the same cycle exactly when `lk_valid` is high and at least one bit of `seg_hit` is set.
- R2: Bit j of `up_match` counts only when j is less than `dev_id`. Other bits are ignored, so device 0 is never blocked.
- R3: One cycle after `lk_valid`, `idx_oe` is high on a device with a local hit when none of its counted `up_match` bits is set. In a full cascade, exactly one device drives the bus in every cycle after reset, and after a lookup with hits it is the hitting device with the smallest identifier.
- R4: The word a winning device drives is {lookup type (top `LT_W` bits), `dev_id` (next 3 bits), segment number (next log2 `SEG_N` bits), in-segment index (low `SEG_IDX_W` bits)`}`. The lowest-numbered hitting segment supplies the location.
- R5: One cycle after a lookup with a local hit, `mm_pull` is high if two or more segments hit, if a hitting segment has its `seg_many` flag set, or if any counted `up_match` bit is set. A `seg_many` flag on a segment that does not hit has no effect. `mm_pull` is low after any cycle with no lookup.
- R6: A device strapped last-SRAM raises `idx_oe` with an all-zero bus word in the cycle after any cycle that is not a lookup with a hit seen in the cascade (its own or a counted `up_match`).
- R7: On the last-device strap, `fb_oe` is high, `fb_valid` follows `lk_valid` delayed by one cycle, and `fb_ack` is high one cycle after a lookup with a hit seen in the cascade. On other devices all three stay low.
- R8: On the last-SRAM strap, `sram_oe` is high, `sram_we` follows `wr_op` delayed by one cycle, and `sram_ce` is high one cycle after `wr_op` or after a lookup with a hit seen in the cascade. On other devices all three stay low.
- R9: While `rst_n` is low, every registered output is 0, so no bus or control line is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_id | input | 3 | Strapped position in the cascade, 0 is highest priority |
| last_dev | input | 1 | Strap: this device drives the host handshake |
| last_sram | input | 1 | Strap: this device drives SRAM control and parks the bus |
| lk_valid | input | 1 | Lookup result of the local table is present this cycle |
| lk_type | input | LT_W | Lookup type carried into the result word |
| seg_hit | input | SEG_N | Per-segment hit flags |
| seg_many | input | SEG_N | Per-segment flag: more than one hit inside the segment |
| seg_idx | input | SEG_N*SEG_IDX_W | Per-segment hit location, segment s in slice s |
| wr_op | input | 1 | SRAM write or learn cycle |
| up_match | input | DEV_N-1 | Cascade match lines, bit j from device j |
| match_out | output | 1 | Local hit indication to lower-priority devices |
| mm_pull | output | 1 | Pull request for the wired-OR multi-match line |
| idx_oe | output | 1 | Result bus output enable |
| idx_bus | output | BUS_W | Result bus word |
| fb_oe | output | 1 | Host handshake output enable |
| fb_valid | output | 1 | Lookup completion to the host |
| fb_ack | output | 1 | Lookup hit to the host |
| sram_oe | output | 1 | SRAM control output enable |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |

## Verification
The arbitration outcome and the multi-match detection are settled in the same cycle, from the same cascade match lines. An eight-device cascade is swept over all 256 device hit patterns with back-to-back lookups. Each pattern also varies the segment hit mix and the in-segment multiple-hit flags. From the pattern alone, the bench works out the lowest hitting identifier, the expected word, and whether any multiple-hit condition holds. It then compares the single active driver, its word and the OR of all pull requests in the following cycle. Idle write cycles are mixed in to check that the bus is parked and that SRAM control is correct between lookups.

// File: rtl/cma_pkg.sv
package cma_pkg;
   // Who owns the result bus in the next cycle.
   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_WIN  = 2'd1,
      DRV_PARK = 2'd2
   } drive_e;

   localparam int unsigned MAX_CASCADE = 8;
endpackage

// File: rtl/cma_seg_pick.sv
// Reduces per-segment results to one local result.
module cma_seg_pick #(
   parameter int SEG_N         = 4,
   parameter int SEG_IDX_W     = 14,
   parameter bit LOW_SEG_FIRST = 1'b1,
   localparam int SEL_W        = $clog2(SEG_N)
) (
   input  logic [SEG_N-1:0]           seg_hit,
   input  logic [SEG_N-1:0]           seg_many,
   input  logic [SEG_N*SEG_IDX_W-1:0] seg_idx,
   output logic                       any_hit,
   output logic [SEL_W-1:0]           sel,
   output logic [SEG_IDX_W-1:0]       loc,
   output logic                       multi
);
   assign any_hit = |seg_hit;
   assign multi   = ($countones(seg_hit) > 1) || (|(seg_hit & seg_many));

   generate
      if (LOW_SEG_FIRST) begin : g_low
         // Walk downward so the smallest hitting segment is written last.
         always_comb begin
            sel = '0;
            loc = '0;
            for (int s = SEG_N - 1; s >= 0; s--) begin
               if (seg_hit[s]) begin
                  sel = SEL_W'(s);
                  loc = seg_idx[s*SEG_IDX_W +: SEG_IDX_W];
               end
            end
         end
      end else begin : g_high
         always_comb begin
            sel = '0;
            loc = '0;
            for (int s = 0; s < SEG_N; s++) begin
               if (seg_hit[s]) begin
                  sel = SEL_W'(s);
                  loc = seg_idx[s*SEG_IDX_W +: SEG_IDX_W];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cma_cascade_gate.sv
// Keeps only match lines from devices with a smaller identifier.
module cma_cascade_gate #(
   parameter int DEV_N = 8,
   localparam int ID_W = $clog2(DEV_N)
) (
   input  logic [ID_W-1:0]  dev_id,
   input  logic [DEV_N-2:0] up_match,
   output logic             blocked
);
   logic [DEV_N-2:0] counted;

   for (genvar j = 0; j < DEV_N - 1; j++) begin : g_line
      assign counted[j] = up_match[j] && (dev_id > ID_W'(j));
   end

   assign blocked = |counted;
endmodule

// File: rtl/cma_out_stage.sv
// Registered ownership, word and strap-gated control outputs.
module cma_out_stage #(
   parameter int BUS_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last_dev,
   input  logic             last_sram,
   input  logic             lk_valid,
   input  logic             hit,
   input  logic             blocked,
   input  logic             multi,
   input  logic             wr_op,
   input  logic [BUS_W-1:0] word,
   output logic             mm_pull,
   output logic             idx_oe,
   output logic [BUS_W-1:0] idx_bus,
   output logic             fb_oe,
   output logic             fb_valid,
   output logic             fb_ack,
   output logic             sram_oe,
   output logic             sram_ce,
   output logic             sram_we
);
   import cma_pkg::*;

   drive_e drv;
   logic   seen_hit;

   assign seen_hit = lk_valid && (hit || blocked);

   always_comb begin
      if (lk_valid && hit && !blocked)
         drv = DRV_WIN;
      else if (last_sram && !seen_hit)
         drv = DRV_PARK;
      else
         drv = DRV_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mm_pull  <= 1'b0;
         idx_oe   <= 1'b0;
         idx_bus  <= '0;
         fb_oe    <= 1'b0;
         fb_valid <= 1'b0;
         fb_ack   <= 1'b0;
         sram_oe  <= 1'b0;
         sram_ce  <= 1'b0;
         sram_we  <= 1'b0;
      end else begin
         mm_pull  <= lk_valid && hit && (multi || blocked);
         idx_oe   <= (drv != DRV_NONE);
         idx_bus  <= (drv == DRV_WIN) ? word : '0;
         fb_oe    <= last_dev;
         fb_valid <= last_dev && lk_valid;
         fb_ack   <= last_dev && seen_hit;
         sram_oe  <= last_sram;
         sram_ce  <= last_sram && (seen_hit || wr_op);
         sram_we  <= last_sram && wr_op;
      end
   end
endmodule

// File: rtl/cascade_match_arbiter.sv
module cascade_match_arbiter #(
   parameter int DEV_N         = 8,
   parameter int SEG_N         = 4,
   parameter int SEG_IDX_W     = 14,
   parameter int LT_W          = 2,
   parameter bit LOW_SEG_FIRST = 1'b1,
   localparam int ID_W         = $clog2(DEV_N),
   localparam int SEL_W        = $clog2(SEG_N),
   localparam int BUS_W        = LT_W + ID_W + SEL_W + SEG_IDX_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ID_W-1:0]            dev_id,
   input  logic                       last_dev,
   input  logic                       last_sram,
   input  logic                       lk_valid,
   input  logic [LT_W-1:0]            lk_type,
   input  logic [SEG_N-1:0]           seg_hit,
   input  logic [SEG_N-1:0]           seg_many,
   input  logic [SEG_N*SEG_IDX_W-1:0] seg_idx,
   input  logic                       wr_op,
   input  logic [DEV_N-2:0]           up_match,
   output logic                       match_out,
   output logic                       mm_pull,
   output logic                       idx_oe,
   output logic [BUS_W-1:0]           idx_bus,
   output logic                       fb_oe,
   output logic                       fb_valid,
   output logic                       fb_ack,
   output logic                       sram_oe,
   output logic                       sram_ce,
   output logic                       sram_we
);
   // Elaboration-time parameter checks.
   if (DEV_N < 2 || DEV_N > int'(cma_pkg::MAX_CASCADE) || (DEV_N & (DEV_N - 1)) != 0) begin : g_bad_dev
      $error("DEV_N must be a power of two from 2 to 8");
   end
   if (SEG_N < 2 || (SEG_N & (SEG_N - 1)) != 0) begin : g_bad_seg
      $error("SEG_N must be a power of two of at least 2");
   end
   if (SEG_IDX_W < 1 || LT_W < 1) begin : g_bad_w
      $error("SEG_IDX_W and LT_W must be positive");
   end

   logic                 hit;
   logic                 multi;
   logic                 blocked;
   logic [SEL_W-1:0]     sel;
   logic [SEG_IDX_W-1:0] loc;
   logic [BUS_W-1:0]     word;

   cma_seg_pick #(
      .SEG_N        (SEG_N),
      .SEG_IDX_W    (SEG_IDX_W),
      .LOW_SEG_FIRST(LOW_SEG_FIRST)
   ) u_pick (
      .seg_hit (seg_hit),
      .seg_many(seg_many),
      .seg_idx (seg_idx),
      .any_hit (hit),
      .sel     (sel),
      .loc     (loc),
      .multi   (multi)
   );

   cma_cascade_gate #(
      .DEV_N(DEV_N)
   ) u_gate (
      .dev_id  (dev_id),
      .up_match(up_match),
      .blocked (blocked)
   );

   assign match_out = lk_valid && hit;
   assign word      = {lk_type, dev_id, sel, loc};

   cma_out_stage #(
      .BUS_W(BUS_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .last_dev (last_dev),
      .last_sram(last_sram),
      .lk_valid (lk_valid),
      .hit      (hit),
      .blocked  (blocked),
      .multi    (multi),
      .wr_op    (wr_op),
      .word     (word),
      .mm_pull  (mm_pull),
      .idx_oe   (idx_oe),
      .idx_bus  (idx_bus),
      .fb_oe    (fb_oe),
      .fb_valid (fb_valid),
      .fb_ack   (fb_ack),
      .sram_oe  (sram_oe),
      .sram_ce  (sram_ce),
      .sram_we  (sram_we)
   );
endmodule

// File: rtl/cma_checker.sv
module cma_checker #(
   parameter int DEV_N = 8,
   parameter int LT_W  = 2,
   parameter int BUS_W = 21,
   localparam int ID_W = $clog2(DEV_N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [ID_W-1:0]  dev_id,
   input logic             last_dev,
   input logic             last_sram,
   input logic             lk_valid,
   input logic [LT_W-1:0]  lk_type,
   input logic             wr_op,
   input logic [DEV_N-2:0] up_match,
   input logic             match_out,
   input logic             mm_pull,
   input logic             idx_oe,
   input logic [BUS_W-1:0] idx_bus,
   input logic             fb_valid,
   input logic             fb_ack,
   input logic             sram_ce,
   input logic             sram_we
);
   logic higher_hit;

   always_comb begin
      higher_hit = 1'b0;
      for (int j = 0; j < DEV_N - 1; j++)
         if (up_match[j] && (int'(dev_id) > j)) higher_hit = 1'b1;
   end

   // R3: an unblocked local hit takes the bus one cycle later
   p_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (match_out && !higher_hit) |=> idx_oe);

   // R2, R3: a counted higher-priority hit keeps this device off the bus
   p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && higher_hit) |=> !idx_oe);

   // R4: the winning word carries the lookup type and device identifier
   p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_out && !higher_hit) |=>
         (idx_bus[BUS_W-1 -: LT_W] == $past(lk_type)) &&
         (idx_bus[BUS_W-LT_W-1 -: ID_W] == $past(dev_id)));

   // R5: a hit below a higher-priority hit pulls multi-match
   p_multi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match_out && higher_hit) |=> mm_pull);

   // R5: no lookup, no pull
   p_nomulti_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !mm_pull);

   // R6: the last-SRAM device parks the bus at zero between lookups
   p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_sram && !lk_valid) |=> (idx_oe && idx_bus == '0));

   // R7: handshake stays low off the last device
   p_fb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !last_dev |=> (!fb_valid && !fb_ack));

   // R8: a write cycle asserts chip and write enable on the last-SRAM device
   p_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (last_sram && wr_op) |=> (sram_we && sram_ce));
endmodule

bind cascade_match_arbiter cma_checker #(
   .DEV_N(DEV_N),
   .LT_W (LT_W),
   .BUS_W(BUS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dev_id   (dev_id),
   .last_dev (last_dev),
   .last_sram(last_sram),
   .lk_valid (lk_valid),
   .lk_type  (lk_type),
   .wr_op    (wr_op),
   .up_match (up_match),
   .match_out(match_out),
   .mm_pull  (mm_pull),
   .idx_oe   (idx_oe),
   .idx_bus  (idx_bus),
   .fb_valid (fb_valid),
   .fb_ack   (fb_ack),
   .sram_ce  (sram_ce),
   .sram_we  (sram_we)
);

// File: tb/cascade_match_arbiter_bench.sv
`timescale 1ns/1ps
module cascade_match_arbiter_bench;
   localparam int ND = 8;
   localparam int SN = 2;
   localparam int SW = 4;
   localparam int LW = 2;
   localparam int BW = LW + 3 + 1 + SW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          lk_valid = 1'b0;
   logic [LW-1:0] lk_type = '0;
   logic          wr_op = 1'b0;
   logic [SN-1:0]    sh_v [ND];
   logic [SN-1:0]    mn_v [ND];
   logic [SN*SW-1:0] ix_v [ND];

   logic [ND-1:0] match_w, mm_w, oe_w, fboe_w, fbv_w, fba_w, soe_w, sce_w, swe_w;
   logic [BW-1:0] bus_w [ND];

   int checks = 0;
   int errors = 0;

   for (genvar g = 0; g < ND; g++) begin : g_dev
      cascade_match_arbiter #(
         .DEV_N(ND), .SEG_N(SN), .SEG_IDX_W(SW), .LT_W(LW), .LOW_SEG_FIRST(1'b1)
      ) u_cascade_match_arbiter (
         .clk(clk), .rst_n(rst_n), .dev_id(3'(g)),
         .last_dev(g == ND - 1), .last_sram(g == ND - 1),
         .lk_valid(lk_valid), .lk_type(lk_type),
         .seg_hit(sh_v[g]), .seg_many(mn_v[g]), .seg_idx(ix_v[g]),
         .wr_op(wr_op), .up_match(match_w[ND-2:0]),
         .match_out(match_w[g]), .mm_pull(mm_w[g]),
         .idx_oe(oe_w[g]), .idx_bus(bus_w[g]),
         .fb_oe(fboe_w[g]), .fb_valid(fbv_w[g]), .fb_ack(fba_w[g]),
         .sram_oe(soe_w[g]), .sram_ce(sce_w[g]), .sram_we(swe_w[g])
      );
   end

   // Stimulus derived arithmetically from the pattern number.
   function automatic logic [1:0] f_sh(int p, int i);
      return ((p >> i) & 1) != 0 ? 2'(((p + i) % 3) + 1) : 2'b00;
   endfunction
   function automatic logic [1:0] f_mn(int p, int i);
      return ((p >> ((i + 3) % 8)) & 1) != 0 ? 2'b01 : 2'b00;
   endfunction
   function automatic logic [3:0] f_ix(int p, int i, int s);
      return 4'((p * 3 + i * 5 + s * 7) & 15);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input int p, input bit valid, input bit wr);
      lk_valid = valid;
      wr_op    = wr;
      lk_type  = LW'(p & 3);
      for (int i = 0; i < ND; i++) begin
         sh_v[i] = valid ? f_sh(p, i) : 2'b00;
         mn_v[i] = f_mn(p, i);
         ix_v[i] = {f_ix(p, i, 1), f_ix(p, i, 0)};
      end
   endtask

   // Registered outputs one cycle after apply(p, valid, wr).
   task automatic check_regs(input int p, input bit valid, input bit wr);
      int  hits;
      int  win;
      bit  multi;
      int  ndrv;
      int  who;
      logic [BW-1:0] exp_word;
      logic [1:0] sh;
      int  s;
      hits = 0; win = -1; multi = 0;
      for (int i = 0; i < ND; i++) begin
         sh = valid ? f_sh(p, i) : 2'b00;
         if (sh != 2'b00) begin
            hits++;
            if (win < 0) win = i;
            if (sh == 2'b11) multi = 1;
            if (sh[0] && f_mn(p, i)[0]) multi = 1;
         end
      end
      if (hits >= 2) multi = 1;
      ndrv = 0; who = -1;
      for (int i = 0; i < ND; i++)
         if (oe_w[i]) begin ndrv++; who = i; end
      check(ndrv == 1, "R3", "driver count", ndrv, 1);
      if (win >= 0) begin
         check(who == win, "R3", "winning device", who, win);
         s = f_sh(p, win)[0] ? 0 : 1;
         exp_word = BW'(((p & 3) << 8) | (win << 5) | (s << 4) | f_ix(p, win, s));
         if (who >= 0)
            check(bus_w[who] == exp_word, "R4", "bus word", int'(bus_w[who]), int'(exp_word));
         if (f_sh(p, 0) != 2'b00)
            check(oe_w[0] == 1'b1, "R2", "device 0 unblocked", int'(oe_w[0]), 1);
      end else begin
         check(who == ND - 1, "R6", "parking device", who, ND - 1);
         check(bus_w[ND-1] == '0, "R6", "parked word", int'(bus_w[ND-1]), 0);
      end
      check((|mm_w) == multi, "R5", "wired-OR multi", int'(|mm_w), int'(multi));
      check(fbv_w == {valid, 7'b0}, "R7", "fb_valid", int'(fbv_w), valid ? 128 : 0);
      check(fba_w == {(win >= 0), 7'b0}, "R7", "fb_ack", int'(fba_w), (win >= 0) ? 128 : 0);
      check(fboe_w == 8'h80, "R7", "fb_oe", int'(fboe_w), 128);
      check(sce_w == {((win >= 0) || wr), 7'b0}, "R8", "sram_ce", int'(sce_w),
            ((win >= 0) || wr) ? 128 : 0);
      check(swe_w == {wr, 7'b0}, "R8", "sram_we", int'(swe_w), wr ? 128 : 0);
      check(soe_w == 8'h80, "R8", "sram_oe", int'(soe_w), 128);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [ND-1:0] exp_m;
      apply(255, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      // R9: reset holds every registered output low despite active inputs
      check(oe_w == 0 && mm_w == 0 && fboe_w == 0 && soe_w == 0 && sce_w == 0
            && swe_w == 0 && fbv_w == 0, "R9", "outputs in reset",
            int'(oe_w | soe_w | fboe_w), 0);
      apply(0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_regs(0, 1'b0, 1'b0);
      for (int p = 0; p < 256; p++) begin
         apply(p, 1'b1, 1'b0);
         #1;
         for (int i = 0; i < ND; i++) exp_m[i] = (f_sh(p, i) != 2'b00);
         check(match_w == exp_m, "R1", "match_out vector", int'(match_w), int'(exp_m));
         @(negedge clk);
         check_regs(p, 1'b1, 1'b0);
         if (p % 16 == 5) begin
            apply(p, 1'b0, 1'b1);
            #1;
            check(match_w == 0, "R1", "match_out idle", int'(match_w), 0);
            @(negedge clk);
            check_regs(p, 1'b0, 1'b1);
         end
      end
      apply(0, 1'b0, 1'b0);
      @(negedge clk);
      check_regs(0, 1'b0, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule